// File: doc/BRIEF.md
# Buffered Serial Transmitter with Host Service Requests

This block sends 8-bit characters on an asynchronous serial line. Characters written by the host go into an eight-deep queue, then into a one-character holding stage, and then into the shift stage that drives the line. Ten characters can be in flight at once. When there is nothing to send, the line sits at mark (logic 1).

The block asks the host for service in one of two ways. In refill mode the request comes when the queue runs dry. The holding and shift stages can still be busy at that point, so the host has about two character times to refill before the line goes quiet. In drain mode the request comes only once every stage is empty and the last stop bit has gone out. This is the safe point to change the line setup. The host ends each service period with a one-cycle end-of-service strobe. Each period between strobes accepts at most eight characters. A character that cannot be accepted is dropped, and a sticky overrun flag records the loss.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `tx_idle` is 1, and `srv_req` and `overrun` are 0.
- R2: Each character goes out as one 0 start bit, then 8 data bits with the least significant bit first, then one 1 stop bit. Each bit lasts `bit_cycles` clock cycles, and a value of 0 is treated as 1.
- R3: On an idle path, a write accepted at clock edge t drives the start bit onto `txd` from edge t+2. Characters leave in the order they were written.
- R4: Up to 10 characters can be held at once (8 in the queue, 1 in the holding stage, 1 in the shift stage). A write that arrives while the queue is full is dropped and sets `overrun`.
- R5: Counting from reset or from an end-of-service strobe, at most 8 writes are accepted. Any further write is dropped and sets `overrun`. A write in the same cycle as the strobe counts toward the new period.
- R6: `overrun` stays at 1 until an end-of-service strobe clears it. A drop in the same cycle as the strobe wins, and the flag stays at 1.
- R7: In refill mode (`req_refill`=1, `req_drain`=0), `srv_req` rises one cycle after the queue becomes empty, even if the holding and shift stages are still occupied.
- R8: In drain mode (`req_drain`=1), `srv_req` rises one cycle after `tx_idle` becomes 1 and is never raised while characters remain.
- R9: When both mode bits are 1, the block behaves as in drain mode.
- R10: Once raised, `srv_req` stays at 1 until `svc_done` is sampled high, and it is 0 from the next cycle.
- R11: After `svc_done`, `srv_req` is not raised again until the request condition has been false and then true again.
- R12: `tx_idle` is 1 exactly when the queue, the holding stage and the shift stage are all empty, and `txd` is 1 whenever `tx_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one character into the transmit path |
| wr_data | input | 8 | Character to write |
| req_refill | input | 1 | Select request on empty queue |
| req_drain | input | 1 | Select request on fully drained path (takes priority) |
| svc_done | input | 1 | End-of-service strobe, one cycle |
| bit_cycles | input | 16 | Clock cycles per serial bit, 0 treated as 1 |
| txd | output | 1 | Serial line, mark when idle |
| srv_req | output | 1 | Service request to the host |
| tx_idle | output | 1 | All characters completely sent |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The timing below counts each write or strobe from the clock edge that samples it.
- `tx_idle` falls one edge after a write.
- On an idle path the start bit follows two edges after a write.
- A request follows one edge after its condition becomes true.
- In refill mode the queue empties two edges after the last of two back-to-back writes, so the request rises three edges after that write.
- `overrun` and the end-of-service clear of `srv_req` take effect on the edge that samples the event.

The bench drives inputs on falling edges and samples at the falling edge that follows the due rising edge. It checks the value one cycle earlier as well, so a result that comes early or late shows up. A line monitor decodes `txd` at the middle of each bit, using the bit length it has programmed. It compares each decoded character against the bench's queue of accepted writes.

// File: rtl/sertx_pkg.sv
// Shared constants and types for the serial transmit path.
package sertx_pkg;
    localparam int CHAR_W     = 8;
    localparam int FRAME_BITS = CHAR_W + 2;   // start + data + stop

    typedef logic [CHAR_W-1:0] char_t;

    // Which condition drives the service request.
    typedef enum logic [1:0] {
        REQ_OFF    = 2'd0,
        REQ_REFILL = 2'd1,
        REQ_DRAIN  = 2'd2
    } req_mode_e;
endpackage

// File: rtl/sertx_fifo.sv
// Character queue. It accepts one push and one pop per cycle.
// Assumes: the caller never pushes when full and never pops when empty.
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  char_t         push_data,
    input  logic          pop,
    output char_t         head,
    output logic [CW-1:0] count
);
    char_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed character.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/sertx_line.sv
// Holding stage, shift stage and bit timer. These take characters from the queue
// and frame them onto the serial line: start 0, data LSB first, stop 1.
// Assumes: bit_cycles changes only while the line is idle.
module sertx_line
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  char_t            q_head,
    input  logic [DIV_W-1:0] bit_cycles,
    output logic             q_pop,
    output logic             hold_busy,
    output logic             shift_busy,
    output logic             txd
);
    localparam int BIW = $clog2(FRAME_BITS);

    char_t                 hold_q;
    logic                  hold_vld;
    logic                  busy;
    logic [FRAME_BITS-1:0] frame_q;
    logic [BIW-1:0]        bit_idx;
    logic [DIV_W-1:0]      baud_cnt;
    logic [DIV_W-1:0]      div_eff;
    logic                  tick;
    logic                  last_tick;
    logic                  take;

    // Bit length: a value of 0 counts as 1.
    assign div_eff   = (bit_cycles == '0) ? DIV_W'(1) : bit_cycles;
    assign tick      = busy && (baud_cnt == div_eff - 1'b1);
    assign last_tick = tick && (bit_idx == BIW'(FRAME_BITS - 1));
    assign take      = hold_vld && (!busy || last_tick);
    assign q_pop     = !hold_vld && !q_empty;

    // Holding stage: refill from the queue, empty when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else if (q_pop) begin
            hold_vld <= 1'b1;
            hold_q   <= q_head;
        end else if (take) begin
            hold_vld <= 1'b0;
        end
    end

    // Bit timer: count the cycles inside each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          baud_cnt <= '0;
        else if (take || tick || !busy) baud_cnt <= '0;
        else                 baud_cnt <= baud_cnt + 1'b1;
    end

    // Shift stage: load a frame, shift one bit per tick, release after stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            frame_q <= '1;
            bit_idx <= '0;
        end else if (take) begin
            busy    <= 1'b1;
            frame_q <= {1'b1, hold_q, 1'b0};
            bit_idx <= '0;
        end else if (last_tick) begin
            busy    <= 1'b0;
            frame_q <= '1;
            bit_idx <= '0;
        end else if (tick) begin
            frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign txd        = busy ? frame_q[0] : 1'b1;
    assign hold_busy  = hold_vld;
    assign shift_busy = busy;
endmodule

// File: rtl/sertx_svc.sv
// Host service logic: the write window cap, the overrun flag and the request
// handshake. The request re-arms only when its condition has been seen false.
// Assumes: svc_done is a one-cycle strobe.
module sertx_svc
    import sertx_pkg::*;
#(
    parameter int BURST_MAX = 8,
    localparam int WCW = $clog2(BURST_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic q_full,
    input  logic q_empty,
    input  logic path_idle,
    input  logic req_refill,
    input  logic req_drain,
    input  logic svc_done,
    output logic push,
    output logic srv_req,
    output logic overrun
);
    logic [WCW-1:0] win_cnt;
    logic [WCW-1:0] win_base;
    logic           drop;
    logic           armed;
    logic           cond;
    req_mode_e      mode;

    // A strobe opens a new window before this cycle's write is counted.
    assign win_base = svc_done ? '0 : win_cnt;
    assign push     = wr_en && !q_full && (win_base < WCW'(BURST_MAX));
    assign drop     = wr_en && !push;

    // Mode select: drain has priority over refill.
    always_comb begin
        if (req_drain)       mode = REQ_DRAIN;
        else if (req_refill) mode = REQ_REFILL;
        else                 mode = REQ_OFF;
    end

    // Request condition for the selected mode.
    always_comb begin
        case (mode)
            REQ_DRAIN:  cond = path_idle;
            REQ_REFILL: cond = q_empty;
            default:    cond = 1'b0;
        endcase
    end

    // Window counter of accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) win_cnt <= '0;
        else        win_cnt <= win_base + WCW'(push);
    end

    // Sticky overrun: a drop sets it, a strobe clears it, and a drop wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (drop)     overrun <= 1'b1;
        else if (svc_done) overrun <= 1'b0;
    end

    // Request handshake with re-arm on a false condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_req <= 1'b0;
            armed   <= 1'b1;
        end else if (srv_req) begin
            armed <= 1'b0;
            if (svc_done) srv_req <= 1'b0;
        end else if (!cond) begin
            armed <= 1'b1;
        end else if (armed) begin
            srv_req <= 1'b1;
            armed   <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Single-channel serial transmit path: queue, holding stage, shift stage and
// host service request logic.
// Assumes: one clock domain, and the host strobes svc_done to close each window.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int BURST_MAX  = 8,
    parameter int DIV_W      = 16,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             req_refill,
    input  logic             req_drain,
    input  logic             svc_done,
    input  logic [DIV_W-1:0] bit_cycles,
    output logic             txd,
    output logic             srv_req,
    output logic             tx_idle,
    output logic             overrun
);
    logic          push;
    logic          pop;
    char_t         head;
    logic [CW-1:0] fifo_cnt;
    logic          q_empty;
    logic          q_full;
    logic          hold_busy;
    logic          shift_busy;

    assign q_empty = (fifo_cnt == '0);
    assign q_full  = (fifo_cnt == CW'(FIFO_DEPTH));
    assign tx_idle = q_empty && !hold_busy && !shift_busy;

    sertx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .count     (fifo_cnt)
    );

    sertx_line #(.DIV_W(DIV_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .q_head     (head),
        .bit_cycles (bit_cycles),
        .q_pop      (pop),
        .hold_busy  (hold_busy),
        .shift_busy (shift_busy),
        .txd        (txd)
    );

    sertx_svc #(.BURST_MAX(BURST_MAX)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .q_full     (q_full),
        .q_empty    (q_empty),
        .path_idle  (tx_idle),
        .req_refill (req_refill),
        .req_drain  (req_drain),
        .svc_done   (svc_done),
        .push       (push),
        .srv_req    (srv_req),
        .overrun    (overrun)
    );
endmodule

// File: rtl/sertx_chk.sv
// Property checker for sertx_top, attached by bind.
module sertx_chk #(
    parameter int FIFO_DEPTH = 8,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_refill,
    input logic          req_drain,
    input logic          svc_done,
    input logic          txd,
    input logic          srv_req,
    input logic          tx_idle,
    input logic          overrun,
    input logic [CW-1:0] fifo_cnt
);
    // R12: a drained path leaves the line at mark.
    p_idle_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    // R10: a request holds until the strobe.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_req && !svc_done) |=> srv_req);

    // R10: the strobe drops the request.
    p_req_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_req && svc_done) |=> !srv_req);

    // R6: overrun is sticky without a strobe.
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !svc_done) |=> overrun);

    // R4: queue occupancy never passes its depth.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(FIFO_DEPTH));

    // R8, R9: in drain mode a new request needs a drained path.
    p_drain_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_drain && !srv_req) |=> (!srv_req || $past(tx_idle)));

    // R7: in refill mode a new request needs an empty queue.
    p_refill_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_refill && !req_drain && !srv_req) |=> (!srv_req || $past(fifo_cnt == '0)));
endmodule

bind sertx_top sertx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_refill (req_refill),
    .req_drain  (req_drain),
    .svc_done   (svc_done),
    .txd        (txd),
    .srv_req    (srv_req),
    .tx_idle    (tx_idle),
    .overrun    (overrun),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/100ps
module test_sertx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        req_refill = 1'b0;
    logic        req_drain = 1'b0;
    logic        svc_done = 1'b0;
    logic [15:0] bit_cycles = 16'd4;
    logic        txd, srv_req, tx_idle, overrun;

    int n_checks = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];

    sertx_top i_sertx_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_refill(req_refill), .req_drain(req_drain), .svc_done(svc_done),
        .bit_cycles(bit_cycles), .txd(txd), .srv_req(srv_req),
        .tx_idle(tx_idle), .overrun(overrun)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic int eff_div(input logic [15:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    // Line monitor: decode txd at bit centres (R2, R3 ordering)
    int         m_act = 0;
    int         m_cnt = 0;
    logic [7:0] m_byte;
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_act == 0) begin
                if (txd == 1'b0) begin m_act = 1; m_cnt = 0; end
            end else m_cnt++;
            if (m_act == 1) begin
                int d, h, k;
                d = eff_div(bit_cycles); h = d / 2;
                if (m_cnt >= h && ((m_cnt - h) % d) == 0) begin
                    k = (m_cnt - h) / d;
                    if (k >= 1 && k <= 8) m_byte[k-1] = txd;
                    if (k == 9) begin
                        check("R2 stop bit", int'(txd), 1);
                        if (exp_q.size() == 0) check("R3 unexpected char", int'(m_byte), -1);
                        else check("R2 R3 char", int'(m_byte), int'(exp_q.pop_front()));
                        m_act = 0;
                    end
                end
            end
        end
    end

    // Called at a negedge; returns at the next negedge (edge t has passed).
    task automatic write1(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe_done();
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !(tx_idle && m_act == 0); i++) @(negedge clk);
    endtask

    initial begin
        int n;
        logic [7:0] b;
        logic bad_req;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 txd", int'(txd), 1);
        check("R1 tx_idle", int'(tx_idle), 1);
        check("R1 srv_req", int'(srv_req), 0);
        check("R1 overrun", int'(overrun), 0);

        // R3 / R12: latency on an idle path
        bit_cycles = 16'd4;
        exp_q.push_back(8'hA5);
        write1(8'hA5);
        check("R12 tx_idle falls", int'(tx_idle), 0);
        @(negedge clk);
        check("R3 line still mark at t+1", int'(txd), 1);
        @(negedge clk);
        check("R3 start bit at t+2", int'(txd), 0);
        wait_idle();

        // R4: ten characters queue, the eleventh is dropped
        bit_cycles = 16'd20;
        strobe_done();
        for (int i = 0; i < 8; i++) begin
            b = 8'(i * 37 + 3); exp_q.push_back(b); write1(b);
        end
        strobe_done();
        for (int i = 0; i < 2; i++) begin
            b = 8'(i * 91 + 17); exp_q.push_back(b); write1(b);
        end
        check("R4 ten held without overrun", int'(overrun), 0);
        write1(8'hEE);
        check("R4 write into full queue sets overrun", int'(overrun), 1);
        strobe_done();
        check("R6 strobe clears overrun", int'(overrun), 0);
        wait_idle();

        // R7 / R10 / R11: refill mode
        req_refill = 1'b1;
        @(negedge clk);
        check("R7 request on empty queue", int'(srv_req), 1);
        repeat (4) @(negedge clk);
        check("R10 request held", int'(srv_req), 1);
        strobe_done();
        check("R10 request cleared by strobe", int'(srv_req), 0);
        repeat (5) @(negedge clk);
        check("R11 no re-raise while condition stays true", int'(srv_req), 0);
        exp_q.push_back(8'h3C);
        write1(8'h3C);
        @(negedge clk);
        check("R11 still low at t+1", int'(srv_req), 0);
        @(negedge clk);
        check("R11 re-raised at t+2", int'(srv_req), 1);
        wait_idle();
        strobe_done();
        exp_q.push_back(8'h81); write1(8'h81);
        exp_q.push_back(8'h7E); write1(8'h7E);
        @(negedge clk);
        @(negedge clk);
        check("R7 no request while queue holds one", int'(srv_req), 0);
        @(negedge clk);
        check("R7 request when queue empties", int'(srv_req), 1);
        check("R7 characters still in hold and shift", int'(tx_idle), 0);

        // R8: drain mode
        req_refill = 1'b0; req_drain = 1'b1;
        strobe_done();
        bad_req = 1'b0;
        for (int i = 0; i < 20000 && !tx_idle; i++) begin
            if (srv_req) bad_req = 1'b1;
            @(negedge clk);
        end
        check("R8 no request while characters remain", int'(bad_req), 0);
        check("R8 low on the cycle tx_idle rises", int'(srv_req), 0);
        @(negedge clk);
        check("R8 request one cycle after drain", int'(srv_req), 1);
        check("R8 line drained", exp_q.size(), 0);

        // R9: both mode bits set behaves as drain mode
        req_refill = 1'b1;
        strobe_done();
        exp_q.push_back(8'h55); write1(8'h55);
        exp_q.push_back(8'hC3); write1(8'hC3);
        repeat (5) @(negedge clk);
        check("R9 empty queue alone does not request", int'(srv_req), 0);
        for (int i = 0; i < 20000 && !tx_idle; i++) @(negedge clk);
        @(negedge clk);
        check("R9 request after full drain", int'(srv_req), 1);
        req_refill = 1'b0; req_drain = 1'b0;
        strobe_done();

        // R2 / R5 / R6: random bursts with random bit lengths
        for (int it = 0; it < 25; it++) begin
            wait_idle();
            bit_cycles = 16'($urandom_range(3, 0));
            strobe_done();
            check("R6 overrun cleared at window start", int'(overrun), 0);
            n = $urandom_range(10, 1);
            for (int i = 0; i < n; i++) begin
                b = 8'($urandom_range(255, 0));
                if (i < 8) exp_q.push_back(b);
                write1(b);
                if ($urandom_range(1, 0) == 1) @(negedge clk);
            end
            check("R5 overrun after window cap", int'(overrun), (n > 8) ? 1 : 0);
        end
        wait_idle();
        repeat (5) @(negedge clk);
        check("R2 all written characters seen", exp_q.size(), 0);
        check("R12 idle line is mark", int'(txd), 1);
        finish_run();
    end
endmodule